// File: doc/BRIEF.md
# Per-line configurable edge detector

The block watches a bank of single-bit input lines and reports, line by line, when an edge of the selected kind appears. Each line has its own 2-bit mode selector and its own mask bit. Both are held in 32-bit registers that are written and read through a simple single-cycle register port. Every clock the block compares each line with its value from the previous sample. A qualifying change produces a one-cycle pulse on that line's event output. A registered flag, raised in the same cycle, reports whether any line fired.

Two states sequence the detection. ST_PRIME is entered on reset. In it the history registers load the current inputs and no event can be produced. The transition "primed" moves the block unconditionally to ST_RUN on the next clock. ST_RUN is held until the next reset, and in it the registered events follow the detected edges. Register writes take effect on the clock edge that accepts them, so they govern detection from the following edge on.

Top module: `edge_watch`

## Requirements
- R1: While reset is asserted, `evt_out` and `evt_any` are 0 and every register offset reads 0 (all modes rising, all masks clear).
- R2: On the first clock after reset is released (state ST_PRIME) no event is produced, even when lines are already high.
- R3: Mode code 00 gives an event one cycle after a line is sampled going 0 to 1, and no event for a 1 to 0 change.
- R4: Mode code 01 gives an event one cycle after a 1 to 0 change, and no event for a 0 to 1 change.
- R5: Mode code 10 gives an event one cycle after every change in either direction.
- R6: Mode code 11 is reserved and never gives an event on its line.
- R7: Line i takes its mode from register offset i/16, bits [2*(i%16)+1 : 2*(i%16)]. A read of an implemented offset returns the value last written to it.
- R8: Line i is masked by register offset 16 + i/32, bit i%32. A mask bit of 1 suppresses every event on that line, and a 0 lets events through.
- R9: Offsets 0 to 31 that hold no implemented register (control offsets at or above NUM_LINES/16, mask offsets at or above 16 + ceil(NUM_LINES/32), and offsets 24 to 31) accept writes with no effect on detection or stored state, and read 0.
- R10: `evt_any` is 1 in exactly the cycles in which at least one bit of `evt_out` is 1.
- R11: An event lasts one cycle. If the line does not change again, the event bit returns to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_in | input | NUM_LINES | Monitored lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_out | output | NUM_LINES | Per-line one-cycle event pulses |
| evt_any | output | 1 | OR of all event bits, same cycle |

## Verification
The bench holds lines high through reset to catch a design that resets its history to zero and then reports false rising edges in the first cycle. It places lines in different control words and field positions. A packing or shift error then shows up as an event on the wrong line or of the wrong kind, and a mask offset error lets a masked line fire or silences a neighbour. It writes all ones to every unimplemented offset and then rechecks read-back and live detection, which exposes an address decode that aliases holes onto real registers. It also toggles a line on every cycle in toggle mode, to show that the pulse logic does not merge back-to-back events, and it checks the reserved code for silence.

// File: rtl/edge_watch_pkg.sv
package edge_watch_pkg;
    localparam int WORD_W         = 32;
    localparam int REG_AW         = 5;
    localparam int LINES_PER_CTRL = 16;
    localparam int LINES_PER_MASK = 32;
    localparam int MASK_BASE      = 16;
    localparam int MAX_LINES      = 256;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_mode_e;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } watch_state_e;
endpackage

// File: rtl/edge_watch_regs.sv
module edge_watch_regs
    import edge_watch_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [REG_AW-1:0]      addr,
    input  logic [WORD_W-1:0]      wdata,
    output logic [WORD_W-1:0]      rdata,
    output logic [2*NUM_LINES-1:0] modes,
    output logic [NUM_LINES-1:0]   masks
);
    localparam int NCTRL = NUM_LINES / LINES_PER_CTRL;
    localparam int NMASK = (NUM_LINES + LINES_PER_MASK - 1) / LINES_PER_MASK;

    logic [WORD_W-1:0]       ctrl_q [NCTRL];
    logic [WORD_W-1:0]       mask_q [NMASK];
    logic [WORD_W*NMASK-1:0] mask_flat;

    for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[c] <= '0;
            else if (we && addr == REG_AW'(c))
                ctrl_q[c] <= wdata;
        end
        assign modes[WORD_W*c +: WORD_W] = ctrl_q[c];
    end

    for (genvar m = 0; m < NMASK; m++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[m] <= '0;
            else if (we && addr == REG_AW'(MASK_BASE + m))
                mask_q[m] <= wdata;
        end
        assign mask_flat[WORD_W*m +: WORD_W] = mask_q[m];
    end

    assign masks = mask_flat[NUM_LINES-1:0];

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCTRL; c++)
            if (addr == REG_AW'(c))
                rdata = ctrl_q[c];
        for (int m = 0; m < NMASK; m++)
            if (addr == REG_AW'(MASK_BASE + m))
                rdata = mask_q[m];
    end

    logic hole_addr;
    assign hole_addr = ((int'(addr) >= NCTRL) && (int'(addr) < MASK_BASE))
                     || (int'(addr) >= MASK_BASE + NMASK);

    // R9: a write to an empty slot leaves the whole configuration untouched
    a_r9_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hole_addr) |=> ($stable(modes) && $stable(mask_flat)));
endmodule

// File: rtl/edge_watch_hit.sv
module edge_watch_hit
    import edge_watch_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic [NUM_LINES-1:0]   prev,
    input  logic [NUM_LINES-1:0]   cur,
    input  logic [2*NUM_LINES-1:0] modes,
    input  logic [NUM_LINES-1:0]   masks,
    output logic [NUM_LINES-1:0]   hit
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic raw;
        always_comb begin
            unique case (edge_mode_e'(modes[2*i +: 2]))
                EDGE_RISE: raw = ~prev[i] &  cur[i];
                EDGE_FALL: raw =  prev[i] & ~cur[i];
                EDGE_BOTH: raw =  prev[i] ^  cur[i];
                EDGE_NONE: raw = 1'b0;
            endcase
        end
        assign hit[i] = raw & ~masks[i];
    end
endmodule

// File: rtl/edge_watch.sv
module edge_watch
    import edge_watch_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic                 reg_we,
    input  logic [4:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_LINES-1:0] evt_out,
    output logic                 evt_any
);
    watch_state_e           state_q, state_d;
    logic [NUM_LINES-1:0]   prev_q;
    logic [NUM_LINES-1:0]   hit;
    logic [2*NUM_LINES-1:0] modes;
    logic [NUM_LINES-1:0]   masks;

    edge_watch_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .modes (modes),
        .masks (masks)
    );

    edge_watch_hit #(.NUM_LINES(NUM_LINES)) u_hit (
        .prev  (prev_q),
        .cur   (lines_in),
        .modes (modes),
        .masks (masks),
        .hit   (hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_PRIME;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= lines_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_out <= '0;
            evt_any <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PRIME: begin
                    evt_out <= '0;
                    evt_any <= 1'b0;
                end
                ST_RUN: begin
                    evt_out <= hit;
                    evt_any <= |hit;
                end
            endcase
        end
    end

    // R2: the priming cycle never reports an event
    a_r2_prime_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |=> (evt_out == '0));

    // R10: the summary flag follows the event bank
    a_r10_any_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        evt_any == (evt_out != '0));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        // R11: a steady line lets its event drop after one cycle
        a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_out[i] && (lines_in[i] == prev_q[i])) |=> !evt_out[i]);
        // R6: the reserved code keeps the line silent
        a_r6_reserved_mute: assert property (@(posedge clk) disable iff (!rst_n)
            (modes[2*i +: 2] == 2'b11) |=> !evt_out[i]);
        // R8: a set mask bit keeps the line silent
        a_r8_mask_mute: assert property (@(posedge clk) disable iff (!rst_n)
            masks[i] |=> !evt_out[i]);
    end
endmodule

// File: tb/edge_watch_bench.sv
module edge_watch_bench;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] lv;
    logic         reg_we;
    logic [4:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic [N-1:0] evt_out;
    logic         evt_any;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    edge_watch #(.NUM_LINES(N)) u_edge_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_in  (lv),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_out   (evt_out),
        .evt_any   (evt_any)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic chk_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read offset %0d: actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_evt(input logic [N-1:0] exp, input string tag);
        n_chk++;
        if (evt_out !== exp || evt_any !== (exp != '0)) begin
            n_fail++;
            $display("FAIL %s events: actual %h/%b expected %h/%b",
                     tag, evt_out, evt_any, exp, (exp != '0));
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // R1: outputs and registers while in reset
    task automatic t_reset();
        chk_evt('0, "R1");
        chk_rd(5'd0, 32'h0, "R1");
        chk_rd(5'd3, 32'h0, "R1");
        chk_rd(5'd16, 32'h0, "R1");
        chk_rd(5'd17, 32'h0, "R1");
    endtask

    // R2: lines high at release must not look like rising edges
    task automatic t_prime();
        rst_n = 1'b1;
        step();
        chk_evt('0, "R2 priming cycle");
        step();
        chk_evt('0, "R2 after priming");
        lv = '0;
        step();
        step();
        chk_evt('0, "R2 settle");
    endtask

    // R3 and R11: rising mode on line 5
    task automatic t_rise();
        lv[5] = 1'b1; step();
        chk_evt(N'(1) << 5, "R3 rise");
        step();
        chk_evt('0, "R11 pulse ends");
        lv[5] = 1'b0; step();
        chk_evt('0, "R3 fall ignored");
    endtask

    // R4: word 0 to falling
    task automatic t_fall();
        wr(5'd0, 32'h5555_5555);
        chk_rd(5'd0, 32'h5555_5555, "R7 readback");
        lv[3] = 1'b1; step();
        chk_evt('0, "R4 rise ignored");
        lv[3] = 1'b0; step();
        chk_evt(N'(1) << 3, "R4 fall");
        step();
        chk_evt('0, "R11 pulse ends");
    endtask

    // R5: word 1 to toggle, line 20 changing every cycle
    task automatic t_toggle();
        wr(5'd1, 32'hAAAA_AAAA);
        lv[20] = 1'b1; step(); chk_evt(N'(1) << 20, "R5 toggle up");
        lv[20] = 1'b0; step(); chk_evt(N'(1) << 20, "R5 toggle down");
        lv[20] = 1'b1; step(); chk_evt(N'(1) << 20, "R5 toggle up again");
        step();               chk_evt('0, "R11 steady line");
        lv[20] = 1'b0; step(); chk_evt(N'(1) << 20, "R5 toggle down again");
    endtask

    // R6: word 2 all reserved
    task automatic t_reserved();
        wr(5'd2, 32'hFFFF_FFFF);
        lv[40] = 1'b1; step(); chk_evt('0, "R6 reserved up");
        lv[40] = 1'b0; step(); chk_evt('0, "R6 reserved down");
    endtask

    // R7: line 49 is bits 3:2 of word 3
    task automatic t_packing();
        wr(5'd3, 32'h0000_0004);
        chk_rd(5'd3, 32'h0000_0004, "R7 readback");
        lv[48] = 1'b1; lv[49] = 1'b1; step();
        chk_evt(N'(1) << 48, "R7 line 48 rising, 49 falling");
        step();
        lv[48] = 1'b0; lv[49] = 1'b0; step();
        chk_evt(N'(1) << 49, "R7 line 49 falling");
    endtask

    // R8: line 48 is bit 16 of offset 17
    task automatic t_mask();
        wr(5'd17, 32'h0001_0000);
        chk_rd(5'd17, 32'h0001_0000, "R8 readback");
        lv[48] = 1'b1; lv[50] = 1'b1; step();
        chk_evt(N'(1) << 50, "R8 masked line 48");
        lv[48] = 1'b0; lv[50] = 1'b0; step();
        wr(5'd17, 32'h0);
        lv[48] = 1'b1; step();
        chk_evt(N'(1) << 48, "R8 unmasked line 48");
        lv[48] = 1'b0; step();
    endtask

    // R9: empty offsets swallow writes
    task automatic t_holes();
        for (int a = 4; a < 32; a++)
            if (a < 16 || a >= 18) wr(5'(a), 32'hFFFF_FFFF);
        for (int a = 4; a < 32; a++)
            if (a < 16 || a >= 18) chk_rd(5'(a), 32'h0, "R9 hole");
        chk_rd(5'd0, 32'h5555_5555, "R9 word 0 kept");
        chk_rd(5'd1, 32'hAAAA_AAAA, "R9 word 1 kept");
        chk_rd(5'd2, 32'hFFFF_FFFF, "R9 word 2 kept");
        chk_rd(5'd3, 32'h0000_0004, "R9 word 3 kept");
        chk_rd(5'd16, 32'h0, "R9 mask 16 kept");
        chk_rd(5'd17, 32'h0, "R9 mask 17 kept");
        lv[3] = 1'b1; step(); chk_evt('0, "R9 line 3 still falling");
        lv[3] = 1'b0; step(); chk_evt(N'(1) << 3, "R9 line 3 falls");
        lv[48] = 1'b1; step(); chk_evt(N'(1) << 48, "R9 line 48 unmasked");
        lv[48] = 1'b0; step();
    endtask

    // R10: several lines at once, mixed modes
    task automatic t_any();
        lv[16] = 1'b1; lv[33] = 1'b1; lv[56] = 1'b1; step();
        chk_evt((N'(1) << 16) | (N'(1) << 56), "R10 multi-line");
        step();
        chk_evt('0, "R10 idle");
    endtask

    initial begin
        rst_n = 1'b0; lv = '1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) step();
        t_reset();
        t_prime();
        t_rise();
        t_fall();
        t_toggle();
        t_reserved();
        t_packing();
        t_mask();
        t_holes();
        t_any();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
            $finish;
        end
    end
endmodule